// File: doc/BRIEF.md
# Rolling-Shutter Row and Column Timing Generator

This block sequences a rolling-shutter pixel array. A read pointer walks the rows in order; when a row is read, the block pulses a transfer strobe with that row's address, so the whole row moves into the column sample stage. It then streams the row one pixel per clock: the active columns first, then the shielded black columns. A reset pointer runs a fixed number of rows ahead of the read pointer and pulses a row-reset strobe with its own address. That row distance, `int_rows`, sets the exposure time in row slots. The ADC data word is passed through to the output while a pixel is valid.

Output framing uses a pixel-valid qualifier, a line sync, a frame sync and a one-cycle frame-start pulse. Horizontal blanking (`hblank` cycles after each line) and vertical blanking (`vblank` row slots after each frame) are set by inputs. A row slot lasts SLOT = 1 + LINE + `hblank` cycles, where LINE = ACT_COLS + BLK_COLS.

With `snap_mode` low, frames repeat without end. With `snap_mode` high, the block waits for a rising edge on `snap_req`. It then sweeps resets over the first `int_rows` rows and reads exactly one frame, holding `busy` high for the whole capture.

The state machine (`tg_state_e`) has six states:
- TG_IDLE: leaves for TG_XFER when `snap_mode` is low, and for TG_PRIME on a snapshot edge.
- TG_PRIME: snapshot reset sweep, one row per slot. After `int_rows` slots it goes to TG_XFER.
- TG_XFER: one cycle. Always goes to TG_SHIFT.
- TG_SHIFT: LINE cycles. At the end it goes to TG_HBLK when `hblank` is not zero. Otherwise it takes the end-of-line decision. On the last row of a snapshot it goes to TG_IDLE.
- TG_HBLK: `hblank` cycles, then the end-of-line decision.
- TG_VBLK: `vblank` slots, then TG_XFER.

The end-of-line decision works as follows:
- If more rows remain, go to TG_XFER.
- After the last row, go to TG_IDLE if `snap_mode` is high.
- Otherwise go to TG_VBLK if `vblank` is not zero, else to TG_XFER.

`soft_rst` forces TG_IDLE from any state.

Top module: `sensor_tg_top`

## Requirements
- R1: While `rst_n` is low, every strobe, sync, `frame_start` and `busy` is 0, and both row addresses are 0.
- R2: Each readout row gives a one-cycle `xfer_strobe` carrying that row on `rd_row`. The next cycle starts LINE cycles of `hsync` = `pix_valid` = 1, with `col_addr` counting 0 to LINE-1. `black_col` is 1 exactly when `col_addr` >= ACT_COLS. `hblank` idle cycles follow.
- R3: In continuous mode, rows are read 0, 1, ..., ROWS-1 and then `vblank` idle slots follow. The frame period is (ROWS + `vblank`) * SLOT cycles. `vsync` is high for ROWS * SLOT cycles of it, and `hsync` is only ever high while `vsync` is high.
- R4: In continuous mode, every `xfer_strobe` cycle also carries `rst_strobe`, with `rst_row` = (`rd_row` + `int_rows`) mod ROWS. When `int_rows` = ROWS, the two addresses are equal.
- R5: `frame_start` is high for exactly one cycle per frame: the transfer cycle of row 0.
- R6: In snapshot mode, no readout happens until a `snap_req` rising edge is seen in TG_IDLE.
  - The first reset strobe (row 0) comes in the first busy cycle, and rows 0 to `int_rows`-1 are reset one per slot.
  - During readout, a reset strobe comes only for rows (`rd_row` + `int_rows`) < ROWS, so each row is reset exactly once.
  - Every row's transfer comes exactly `int_rows` * SLOT cycles after its reset.
- R7: `busy` goes high the cycle after the trigger edge and falls right after the last black pixel of row ROWS-1. It is high for (`int_rows` + ROWS - 1) * SLOT + 1 + LINE cycles and covers exactly one frame. Edges on `snap_req` while `busy` is high are ignored, and no further frame follows.
- R8: When `soft_rst` is high at a clock edge, then in the next cycle `vsync`, `hsync`, `xfer_strobe`, `rst_strobe`, `frame_start` and `busy` are 0 and `rd_row` is 0. After release in continuous mode, row 0 is transferred in the first cycle.
- R9: `pix_out` equals `adc_data` while `pix_valid` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart to TG_IDLE |
| snap_mode | input | 1 | 1 = single-frame snapshot, 0 = continuous |
| snap_req | input | 1 | Snapshot request, acted on at its rising edge |
| int_rows | input | RW | Exposure in row slots, 1..ROWS (values outside are clamped) |
| hblank | input | HW | Idle cycles after each line |
| vblank | input | VW | Idle row slots after each frame |
| adc_data | input | DW | Converted pixel from the ADC |
| rst_strobe | output | 1 | Row reset pulse |
| rst_row | output | RW | Row address for the reset pulse |
| xfer_strobe | output | 1 | Row transfer pulse into the column stage |
| rd_row | output | RW | Read pointer row address |
| col_addr | output | CW | Column being shifted out |
| black_col | output | 1 | Current column is a shielded black column |
| pix_valid | output | 1 | Pixel clock enable |
| hsync | output | 1 | Line sync, high while line pixels are valid |
| vsync | output | 1 | Frame sync over the readout rows |
| frame_start | output | 1 | One-cycle start-of-frame pulse |
| busy | output | 1 | Snapshot capture in progress |
| pix_out | output | DW | Framed pixel data |

## Verification
The continuous sequence is tried with several combinations of exposure, line blanking and frame blanking. This includes zero blanking on both axes and an exposure equal to the row count, which separates off-by-one errors in slot length and wrap from errors in the end-of-frame path. For each combination, the bench measures the frame period and the pixel, black-column and sync counts. It also checks the row order, the column sequence and the reset-row lead. Snapshots are run with a short exposure and with a full-array exposure. They time every row's reset-to-transfer distance and the busy window, and re-trigger during capture to show the edge is ignored. Directed soft-reset and power-on checks cover the idle state.

// File: rtl/sensor_tg_pkg.sv
package sensor_tg_pkg;
    typedef enum logic [2:0] {
        TG_IDLE,
        TG_PRIME,
        TG_XFER,
        TG_SHIFT,
        TG_HBLK,
        TG_VBLK
    } tg_state_e;
endpackage

// File: rtl/sensor_tg_ticker.sv
module sensor_tg_ticker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (en)     cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/sensor_tg_rise.sv
module sensor_tg_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end
    assign rise = din & ~prev_q;
endmodule

// File: rtl/sensor_tg_rowptr.sv
module sensor_tg_rowptr #(
    parameter int ROWS = 1032,
    localparam int RW = $clog2(ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [RW-1:0] lead,
    output logic [RW-1:0] rd_row,
    output logic [RW-1:0] rst_row,
    output logic          rd_last,
    output logic          lead_wraps
);
    logic [RW:0] sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_row <= '0;
        else if (clr)      rd_row <= '0;
        else if (step)     rd_row <= rd_last ? '0 : rd_row + RW'(1);
    end

    assign rd_last    = (rd_row == RW'(ROWS - 1));
    assign sum        = {1'b0, rd_row} + {1'b0, lead};
    assign lead_wraps = (sum >= (RW+1)'(ROWS));
    assign rst_row    = lead_wraps ? RW'(sum - (RW+1)'(ROWS)) : sum[RW-1:0];

    // R3: the read pointer wraps to row 0 after the last row
    assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && rd_last) |=> (rd_row == '0));
endmodule

// File: rtl/sensor_tg_top.sv
module sensor_tg_top #(
    parameter int ROWS     = 1032,
    parameter int ACT_COLS = 1288,
    parameter int BLK_COLS = 24,
    parameter int HW       = 12,
    parameter int VW       = 8,
    parameter int DW       = 10,
    localparam int LINE = ACT_COLS + BLK_COLS,
    localparam int RW   = $clog2(ROWS + 1),
    localparam int CW   = $clog2(LINE),
    localparam int CYW  = ((CW > HW) ? CW : HW) + 2,
    localparam int SW   = (RW > VW) ? RW : VW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          snap_mode,
    input  logic          snap_req,
    input  logic [RW-1:0] int_rows,
    input  logic [HW-1:0] hblank,
    input  logic [VW-1:0] vblank,
    input  logic [DW-1:0] adc_data,
    output logic          rst_strobe,
    output logic [RW-1:0] rst_row,
    output logic          xfer_strobe,
    output logic [RW-1:0] rd_row,
    output logic [CW-1:0] col_addr,
    output logic          black_col,
    output logic          pix_valid,
    output logic          hsync,
    output logic          vsync,
    output logic          frame_start,
    output logic          busy,
    output logic [DW-1:0] pix_out
);
    import sensor_tg_pkg::*;

    tg_state_e      state_q, state_d;
    logic           snap_run_q, run_set, run_clr;
    logic           snap_rise;
    logic [CYW-1:0] cyc, slot_max;
    logic [SW-1:0]  sub;
    logic           cyc_clr, sub_clr, sub_en, slot_end;
    logic           row_step, row_clr, line_done;
    logic [RW-1:0]  n_eff, lead_row;
    logic           rd_last, lead_wraps;

    always_comb begin
        if (int_rows == '0)               n_eff = RW'(1);
        else if (int_rows > RW'(ROWS))    n_eff = RW'(ROWS);
        else                              n_eff = int_rows;
    end

    assign slot_max = CYW'(LINE) + CYW'(hblank);
    assign slot_end = (cyc == slot_max);

    sensor_tg_rise u_rise (
        .clk(clk), .rst_n(rst_n), .din(snap_req), .rise(snap_rise)
    );

    sensor_tg_ticker #(.W(CYW)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .en(1'b1), .cnt(cyc)
    );

    sensor_tg_ticker #(.W(SW)) u_sub (
        .clk(clk), .rst_n(rst_n), .clr(sub_clr), .en(sub_en), .cnt(sub)
    );

    sensor_tg_rowptr #(.ROWS(ROWS)) u_rows (
        .clk(clk), .rst_n(rst_n), .clr(row_clr), .step(row_step),
        .lead(n_eff), .rd_row(rd_row), .rst_row(lead_row),
        .rd_last(rd_last), .lead_wraps(lead_wraps)
    );

    // next state
    always_comb begin
        state_d   = state_q;
        row_step  = 1'b0;
        row_clr   = soft_rst;
        run_set   = 1'b0;
        run_clr   = soft_rst;
        line_done = 1'b0;
        unique case (state_q)
            TG_IDLE: begin
                if (!snap_mode) begin
                    state_d = TG_XFER;
                end else if (snap_rise) begin
                    state_d = TG_PRIME;
                    run_set = 1'b1;
                    row_clr = 1'b1;
                end
            end
            TG_PRIME:
                if (slot_end && sub == SW'(n_eff) - SW'(1)) state_d = TG_XFER;
            TG_XFER:
                state_d = TG_SHIFT;
            TG_SHIFT: begin
                if (cyc == CYW'(LINE - 1)) begin
                    if (snap_run_q && rd_last) begin
                        state_d  = TG_IDLE;
                        run_clr  = 1'b1;
                        row_step = 1'b1;
                    end else if (hblank == '0) begin
                        line_done = 1'b1;
                    end else begin
                        state_d = TG_HBLK;
                    end
                end
            end
            TG_HBLK:
                if (cyc == CYW'(hblank) - CYW'(1)) line_done = 1'b1;
            TG_VBLK:
                if (slot_end && sub == SW'(vblank) - SW'(1)) state_d = TG_XFER;
            default:
                state_d = TG_IDLE;
        endcase
        if (line_done) begin
            row_step = 1'b1;
            if (!rd_last)           state_d = TG_XFER;
            else if (snap_mode)     state_d = TG_IDLE;
            else if (vblank != '0)  state_d = TG_VBLK;
            else                    state_d = TG_XFER;
        end
        if (soft_rst) state_d = TG_IDLE;
    end

    assign cyc_clr = soft_rst || (state_d != state_q) ||
                     ((state_q == TG_PRIME || state_q == TG_VBLK) && slot_end);
    assign sub_clr = soft_rst || (state_d != state_q);
    assign sub_en  = (state_q == TG_PRIME || state_q == TG_VBLK) && slot_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TG_IDLE;
            snap_run_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (run_clr)      snap_run_q <= 1'b0;
            else if (run_set) snap_run_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rst_strobe  = 1'b0;
        rst_row     = '0;
        xfer_strobe = 1'b0;
        col_addr    = '0;
        black_col   = 1'b0;
        hsync       = 1'b0;
        vsync       = 1'b0;
        frame_start = 1'b0;
        unique case (state_q)
            TG_PRIME: begin
                rst_strobe = (cyc == '0);
                rst_row    = sub[RW-1:0];
            end
            TG_XFER: begin
                xfer_strobe = 1'b1;
                vsync       = 1'b1;
                rst_strobe  = snap_run_q ? !lead_wraps : 1'b1;
                rst_row     = lead_row;
                frame_start = (rd_row == '0);
            end
            TG_SHIFT: begin
                hsync     = 1'b1;
                vsync     = 1'b1;
                col_addr  = cyc[CW-1:0];
                black_col = (cyc >= CYW'(ACT_COLS));
            end
            TG_HBLK:  vsync = 1'b1;
            default: ;
        endcase
    end

    assign pix_valid = hsync;
    assign busy      = snap_run_q;
    assign pix_out   = hsync ? adc_data : '0;

    // R2: a transfer is followed by the first shifted pixel
    assert_xfer_then_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && !soft_rst) |=> (hsync && col_addr == '0));

    // R3: line sync only inside the frame window
    assert_hsync_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> vsync);

    // R8: soft reset clears framing within one clock
    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!vsync && !hsync && !xfer_strobe && !busy && rd_row == '0));

    // R7: capture ends only after the final pixel of a line
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(soft_rst)) |->
            ($past(hsync) && $past(col_addr) == CW'(LINE - 1)));
endmodule

// File: tb/sensor_tg_top_tb_top.sv
module sensor_tg_top_tb_top;
    localparam int ROWS = 4, ACT = 3, BLK = 2, LINE = ACT + BLK;
    localparam int HW = 4, VW = 3, DW = 10;
    localparam int RW = $clog2(ROWS + 1), CW = $clog2(LINE);
    localparam int NV = 4;
    // {int_rows, hblank, vblank}
    localparam int CFG [NV][3] = '{'{1, 2, 1}, '{4, 0, 0}, '{2, 3, 2}, '{3, 1, 0}};

    logic clk = 0, rst_n = 0, soft_rst = 0, snap_mode = 0, snap_req = 0;
    logic [RW-1:0] int_rows = RW'(1);
    logic [HW-1:0] hblank = '0;
    logic [VW-1:0] vblank = '0;
    logic [DW-1:0] adc_data = '0;
    logic rst_strobe, xfer_strobe, black_col, pix_valid, hsync, vsync, frame_start, busy;
    logic [RW-1:0] rst_row, rd_row;
    logic [CW-1:0] col_addr;
    logic [DW-1:0] pix_out;

    int errors = 0, checks = 0, wd = 0;

    always #5 clk = ~clk;
    always @(posedge clk) adc_data <= adc_data + DW'(7);

    sensor_tg_top #(.ROWS(ROWS), .ACT_COLS(ACT), .BLK_COLS(BLK), .HW(HW), .VW(VW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .snap_mode(snap_mode),
        .snap_req(snap_req), .int_rows(int_rows), .hblank(hblank), .vblank(vblank),
        .adc_data(adc_data), .rst_strobe(rst_strobe), .rst_row(rst_row),
        .xfer_strobe(xfer_strobe), .rd_row(rd_row), .col_addr(col_addr),
        .black_col(black_col), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
        .frame_start(frame_start), .busy(busy), .pix_out(pix_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            chk(0, "watchdog", wd, 100000);
            finish_run();
        end
    end

    task automatic restart(input bit mode, input int n, input int h, input int v);
        @(negedge clk);
        soft_rst = 1;
        snap_mode = mode; int_rows = RW'(n); hblank = HW'(h); vblank = VW'(v);
        @(negedge clk);
        @(negedge clk);
        soft_rst = 0;
    endtask

    // measure one continuous frame between consecutive frame_start pulses
    task automatic cont_frame(input int n, input int h, input int v);
        int slot, per, hs, bl, vs, fs, rowexp, colexp, bad_rst, bad_row, bad_col, bad_pix;
        slot = 1 + LINE + h;
        per = 0; hs = 0; bl = 0; vs = 0; fs = 0; rowexp = 0; colexp = 0;
        bad_rst = 0; bad_row = 0; bad_col = 0; bad_pix = 0;
        for (int i = 0; i < 400 && !frame_start; i++) @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            if (i > 0 && frame_start) break;
            per++;
            if (frame_start) fs++;
            if (vsync) vs++;
            if (xfer_strobe) begin
                if (int'(rd_row) != rowexp) bad_row++;
                if (!rst_strobe || int'(rst_row) != (int'(rd_row) + n) % ROWS) bad_rst++;
                rowexp++; colexp = 0;
            end
            if (hsync) begin
                hs++;
                if (black_col) bl++;
                if (int'(col_addr) != colexp || black_col != (colexp >= ACT) || !pix_valid) bad_col++;
                colexp++;
            end
            if (pix_out != (pix_valid ? adc_data : '0)) bad_pix++;
            @(negedge clk);
        end
        chk(per == (ROWS + v) * slot, "R3 frame period", per, (ROWS + v) * slot);
        chk(vs == ROWS * slot, "R3 vsync cycles", vs, ROWS * slot);
        chk(bad_row == 0 && rowexp == ROWS, "R3 row order", rowexp, ROWS);
        chk(hs == ROWS * LINE, "R2 hsync cycles", hs, ROWS * LINE);
        chk(bl == ROWS * BLK, "R2 black columns", bl, ROWS * BLK);
        chk(bad_col == 0, "R2 column sequence", bad_col, 0);
        chk(bad_rst == 0, "R4 reset row lead", bad_rst, 0);
        chk(fs == 1 && frame_start, "R5 frame_start once", fs, 1);
        chk(bad_pix == 0, "R9 pixel gating", bad_pix, 0);
    endtask

    // one snapshot capture with a re-trigger during busy
    task automatic snap_frame(input int n, input int h);
        int slot, t, rst_n_cnt, xf, fs, hs, bad, first_rst, quiet;
        int rst_t [ROWS];
        int xf_t [ROWS];
        slot = 1 + LINE + h;
        t = 0; rst_n_cnt = 0; xf = 0; fs = 0; hs = 0; bad = 0; first_rst = 0; quiet = 0;
        for (int r = 0; r < ROWS; r++) begin rst_t[r] = -1000; xf_t[r] = -1; end
        snap_req = 0;
        @(negedge clk); @(negedge clk);
        snap_req = 1;
        @(negedge clk);
        while (busy && t < 1000) begin
            if (rst_strobe) begin
                rst_n_cnt++;
                rst_t[int'(rst_row)] = t;
                if (t == 0 && rst_row == '0) first_rst = 1;
            end
            if (xfer_strobe) begin xf++; xf_t[int'(rd_row)] = t; end
            if (frame_start) fs++;
            if (hsync) hs++;
            if (t == 10) snap_req = 0;
            if (t == 12) snap_req = 1;
            t++;
            @(negedge clk);
        end
        for (int r = 0; r < ROWS; r++) if (xf_t[r] - rst_t[r] != n * slot) bad++;
        chk(t == (n + ROWS - 1) * slot + 1 + LINE, "R7 busy length", t, (n + ROWS - 1) * slot + 1 + LINE);
        chk(first_rst == 1, "R6 first reset in first busy cycle", first_rst, 1);
        chk(bad == 0, "R6 per-row exposure", bad, 0);
        chk(rst_n_cnt == ROWS, "R6 reset strobes", rst_n_cnt, ROWS);
        chk(xf == ROWS && fs == 1 && hs == ROWS * LINE, "R7 one frame", hs, ROWS * LINE);
        for (int i = 0; i < 40; i++) begin
            if (busy || hsync || vsync) quiet++;
            @(negedge clk);
        end
        chk(quiet == 0, "R7 re-trigger ignored, no further frame", quiet, 0);
        snap_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rst_strobe && !xfer_strobe && !hsync && !vsync && !frame_start && !busy && !pix_valid,
            "R1 reset outputs", int'({rst_strobe, xfer_strobe, hsync, vsync, busy}), 0);
        chk(rd_row == '0 && rst_row == '0, "R1 reset addresses", int'(rd_row), 0);
        soft_rst = 1;
        @(negedge clk);
        rst_n = 1;

        for (int k = 0; k < NV; k++) begin
            restart(0, CFG[k][0], CFG[k][1], CFG[k][2]);
            cont_frame(CFG[k][0], CFG[k][1], CFG[k][2]);
        end

        // soft reset in mid-frame
        restart(0, 2, 1, 1);
        repeat (9) @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        chk(!vsync && !hsync && !xfer_strobe && !rst_strobe && !frame_start, "R8 syncs cleared",
            int'({vsync, hsync, xfer_strobe}), 0);
        chk(rd_row == '0, "R8 read row cleared", int'(rd_row), 0);
        soft_rst = 0;
        @(negedge clk);
        chk(xfer_strobe && frame_start && rd_row == '0, "R8 restart at row 0",
            int'({xfer_strobe, frame_start}), 3);

        // snapshot mode
        restart(1, 2, 1, 1);
        repeat (5) @(negedge clk);
        chk(!busy && !vsync && !xfer_strobe, "R6 idle until trigger", int'({busy, vsync}), 0);
        snap_frame(2, 1);
        restart(1, ROWS, 1, 0);
        snap_frame(ROWS, 1);

        // soft reset aborts a capture
        snap_req = 0;
        @(negedge clk);
        snap_req = 1;
        repeat (6) @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        chk(!busy && !rst_strobe, "R8 busy cleared", int'(busy), 0);
        soft_rst = 0; snap_req = 0;
        @(negedge clk);
        finish_run();
    end
endmodule